// File: doc/BRIEF.md
# Cycle-Driven Event Timing Wheel

This block holds event identifiers and releases each one a chosen number of cycles later. A wheel of `SLOTS` slots is indexed by the current time taken modulo the wheel size. Each slot is a small last-in-first-out stack of up to `DEPTH` identifiers. The current time is not kept inside the block. It is the sum of five cycle counters supplied from outside: sequential, non-sequential, idle, coprocessor and fast cycles.

A request carries a delay and an identifier. The target slot is a reference time plus the delay, modulo the wheel size. The reference time is latched from the current time only when a request is accepted while no events are outstanding. Later requests keep using that latched value until the wheel drains.

Whenever the current slot differs from the slot reached by the previous sweep, a sweep walks every slot from the previous slot through the current one, both ends included. If the current slot is numerically lower, the walk runs to the top of the wheel and then continues from slot 0. Identifiers come out one at a time on a valid/ready stream. The walk waits while the consumer is not ready.

The sweep engine has three states:
- `SW_IDLE`: waits for a time change. The transition `IDLE->SCAN` happens when the current slot differs from the previous slot; it loads the cursor with the previous slot and the stop point with the current slot.
- `SW_SCAN`: looks at the slot under the cursor. `SCAN->EMIT` happens when that slot is non-empty. `SCAN->IDLE` happens when the slot is empty and the cursor has reached the stop point. `SCAN->SCAN` happens when the slot is empty and the cursor has not reached the stop point; the cursor advances by one, modulo the wheel size.
- `SW_EMIT`: presents the top entry of the slot. `EMIT->SCAN` happens on a handshake that takes the last entry. `EMIT->EMIT` happens otherwise.

Top module: `timing_wheel`

## Requirements
- R1: An accepted request is stored in slot (reference + delay) mod `SLOTS`. Only the low log2(`SLOTS`) bits of the delay take part in this sum.
- R2: The reference is loaded from the current slot only when a request is accepted while `pending_count` is 0. Otherwise the reference keeps its earlier value.
- R3: A request with delay 0 is dropped. `sched_reject` is 1 in the cycle after the request, and `pending_count` does not change.
- R4: A sweep covers every slot from the previous slot through the current slot, both included. An event placed in the previous slot therefore fires on the next time change.
- R5: When the current slot is below the previous slot, the sweep visits the previous slot up to slot `SLOTS`-1 and then slot 0 up to the current slot. Events come out in that slot order.
- R6: The current slot is (seq + nseq + idle + copr + fast) mod `SLOTS`, where these are the five cycle-counter inputs.
- R7: A time change that leaves the current slot equal to the previous slot fires nothing.
- R8: A slot holds at most `DEPTH` identifiers, and they fire newest first. A request aimed at a full slot is dropped, and `sched_reject` is 1 in the next cycle.
- R9: Identifiers leave one per handshake. While `fire_valid` is 1 and `fire_ready` is 0, `fire_valid` stays 1 and `fire_id` holds its value.
- R10: `pending_count` rises by one for each accepted request and falls by one for each handshake. It never exceeds `SLOTS`*`DEPTH`, and `fire_valid` is 0 whenever it is 0.
- R11: After reset, `fire_valid`, `sched_reject` and `pending_count` are 0, and the previous slot is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sched_valid | input | 1 | Schedule request strobe, one cycle per request |
| sched_delay | input | DLY_W | Delay in cycles; 0 is rejected |
| sched_id | input | ID_W | Identifier to schedule |
| sched_reject | output | 1 | High in the cycle after a dropped request |
| cyc_seq | input | CNT_W | Sequential cycle counter |
| cyc_nseq | input | CNT_W | Non-sequential cycle counter |
| cyc_idle | input | CNT_W | Idle cycle counter |
| cyc_copr | input | CNT_W | Coprocessor cycle counter |
| cyc_fast | input | CNT_W | Fast cycle counter |
| fire_valid | output | 1 | A fired identifier is presented |
| fire_ready | input | 1 | The consumer takes the identifier |
| fire_id | output | ID_W | Fired identifier |
| pending_count | output | PEND_W | Number of events outstanding |

## Verification
The stability check on `fire_id` assumes that no request arrives in a cycle where the output is stalled, because a new entry in the slot under the cursor would become the new top. The pending-count checks assume each request lasts exactly one cycle. The stimulus keeps to both rules. It schedules only while the sweep is idle, and it raises every request for a single cycle. After each change of the time counters, it waits long enough for a full sweep to finish before it inspects the fired identifiers.

// File: rtl/tw_pkg.sv
package tw_pkg;
    typedef enum logic [1:0] {
        SW_IDLE = 2'd0,
        SW_SCAN = 2'd1,
        SW_EMIT = 2'd2
    } sweep_state_e;
endpackage

// File: rtl/tw_time_sum.sv
// Folds the five cycle counters into a wheel slot index.
module tw_time_sum #(
    parameter int CNT_W  = 32,
    parameter int SLOT_W = 4
) (
    input  logic [CNT_W-1:0]  cyc_seq,
    input  logic [CNT_W-1:0]  cyc_nseq,
    input  logic [CNT_W-1:0]  cyc_idle,
    input  logic [CNT_W-1:0]  cyc_copr,
    input  logic [CNT_W-1:0]  cyc_fast,
    output logic [SLOT_W-1:0] now_slot
);
    logic [CNT_W-1:0] total;

    // Only the low bits matter modulo a power-of-two wheel.
    assign total    = cyc_seq + cyc_nseq + cyc_idle + cyc_copr + cyc_fast;
    assign now_slot = total[SLOT_W-1:0];
endmodule

// File: rtl/tw_slot_store.sv
// Per-slot LIFO stacks with one push port and one pop/read port.
module tw_slot_store #(
    parameter int SLOTS = 16,
    parameter int DEPTH = 4,
    parameter int ID_W  = 8
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic                         push,
    input  logic [$clog2(SLOTS)-1:0]     push_slot,
    input  logic [ID_W-1:0]              push_id,
    input  logic                         pop,
    input  logic [$clog2(SLOTS)-1:0]     rd_slot,
    output logic                         push_full,
    output logic [$clog2(DEPTH+1)-1:0]   rd_fill,
    output logic [ID_W-1:0]              rd_id
);
    localparam int SLOT_W = $clog2(SLOTS);
    localparam int FW     = $clog2(DEPTH + 1);
    localparam int IW     = $clog2(DEPTH);

    logic [SLOTS-1:0][FW-1:0]   fill_vec;
    logic [SLOTS-1:0][ID_W-1:0] top_vec;

    for (genvar s = 0; s < SLOTS; s++) begin : g_slot
        logic [ID_W-1:0] mem [DEPTH];
        logic [FW-1:0]   cnt;
        logic            hit_push;
        logic            hit_pop;
        logic [IW-1:0]   wr_idx;
        logic [IW-1:0]   top_idx;

        assign hit_push = push && (push_slot == SLOT_W'(s));
        assign hit_pop  = pop  && (rd_slot   == SLOT_W'(s));
        // A simultaneous pop frees the top cell, so the push reuses it.
        assign wr_idx   = IW'(cnt - FW'(hit_pop));
        assign top_idx  = IW'(cnt - FW'(1));

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) cnt <= '0;
            else        cnt <= cnt + FW'(hit_push) - FW'(hit_pop);
        end

        always_ff @(posedge clk) begin
            if (hit_push) mem[wr_idx] <= push_id;
        end

        assign fill_vec[s] = cnt;
        assign top_vec[s]  = mem[top_idx];
    end

    assign push_full = (fill_vec[push_slot] == FW'(DEPTH));
    assign rd_fill   = fill_vec[rd_slot];
    assign rd_id     = top_vec[rd_slot];
endmodule

// File: rtl/tw_sweep_fsm.sv
// Walks slots from the previous time through the current time, wrapping.
module tw_sweep_fsm
    import tw_pkg::*;
#(
    parameter int SLOTS = 16,
    parameter int DEPTH = 4
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic [$clog2(SLOTS)-1:0]   now_slot,
    input  logic [$clog2(DEPTH+1)-1:0] rd_fill,
    input  logic                       fire_ready,
    output logic [$clog2(SLOTS)-1:0]   cursor,
    output logic                       fire_valid,
    output logic                       pop
);
    localparam int SLOT_W = $clog2(SLOTS);
    localparam int FW     = $clog2(DEPTH + 1);

    sweep_state_e      state_q, state_d;
    logic [SLOT_W-1:0] cursor_q, cursor_d;
    logic [SLOT_W-1:0] stop_q, stop_d;
    logic [SLOT_W-1:0] prev_q, prev_d;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q  <= SW_IDLE;
            cursor_q <= '0;
            stop_q   <= '0;
            prev_q   <= '0;
        end else begin
            state_q  <= state_d;
            cursor_q <= cursor_d;
            stop_q   <= stop_d;
            prev_q   <= prev_d;
        end
    end

    always_comb begin
        state_d  = state_q;
        cursor_d = cursor_q;
        stop_d   = stop_q;
        prev_d   = prev_q;
        unique case (state_q)
            SW_IDLE: begin
                if (now_slot != prev_q) begin
                    cursor_d = prev_q;
                    stop_d   = now_slot;
                    prev_d   = now_slot;
                    state_d  = SW_SCAN;
                end
            end
            SW_SCAN: begin
                if (rd_fill != '0) begin
                    state_d = SW_EMIT;
                end else if (cursor_q == stop_q) begin
                    state_d = SW_IDLE;
                end else begin
                    // Power-of-two wheel: the increment wraps to slot 0.
                    cursor_d = cursor_q + SLOT_W'(1);
                end
            end
            SW_EMIT: begin
                if (fire_ready && rd_fill == FW'(1)) state_d = SW_SCAN;
            end
            default: state_d = SW_IDLE;
        endcase
    end

    always_comb begin
        cursor     = cursor_q;
        fire_valid = (state_q == SW_EMIT);
        pop        = (state_q == SW_EMIT) && fire_ready;
    end
endmodule

// File: rtl/timing_wheel.sv
module timing_wheel #(
    parameter int SLOTS = 16,
    parameter int DEPTH = 4,
    parameter int ID_W  = 8,
    parameter int DLY_W = 8,
    parameter int CNT_W = 32,
    parameter int PEND_W = $clog2(SLOTS * DEPTH + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sched_valid,
    input  logic [DLY_W-1:0]  sched_delay,
    input  logic [ID_W-1:0]   sched_id,
    output logic              sched_reject,
    input  logic [CNT_W-1:0]  cyc_seq,
    input  logic [CNT_W-1:0]  cyc_nseq,
    input  logic [CNT_W-1:0]  cyc_idle,
    input  logic [CNT_W-1:0]  cyc_copr,
    input  logic [CNT_W-1:0]  cyc_fast,
    output logic              fire_valid,
    input  logic              fire_ready,
    output logic [ID_W-1:0]   fire_id,
    output logic [PEND_W-1:0] pending_count
);
    localparam int SLOT_W = $clog2(SLOTS);
    localparam int FW     = $clog2(DEPTH + 1);

    logic [SLOT_W-1:0] now_slot;
    logic [SLOT_W-1:0] ref_slot;
    logic [SLOT_W-1:0] base_slot;
    logic [SLOT_W-1:0] target_slot;
    logic [SLOT_W-1:0] cursor;
    logic [FW-1:0]     rd_fill;
    logic              push_full;
    logic              accept;
    logic              pop;
    logic [PEND_W-1:0] pend_q;

    tw_time_sum #(.CNT_W(CNT_W), .SLOT_W(SLOT_W)) u_time (
        .cyc_seq  (cyc_seq),
        .cyc_nseq (cyc_nseq),
        .cyc_idle (cyc_idle),
        .cyc_copr (cyc_copr),
        .cyc_fast (cyc_fast),
        .now_slot (now_slot)
    );

    // The reference follows the current time only while the wheel is empty.
    assign base_slot   = (pend_q == '0) ? now_slot : ref_slot;
    assign target_slot = base_slot + sched_delay[SLOT_W-1:0];
    assign accept      = sched_valid && (sched_delay != '0) && !push_full;

    tw_slot_store #(.SLOTS(SLOTS), .DEPTH(DEPTH), .ID_W(ID_W)) u_store (
        .clk       (clk),
        .rst_n     (rst_n),
        .push      (accept),
        .push_slot (target_slot),
        .push_id   (sched_id),
        .pop       (pop),
        .rd_slot   (cursor),
        .push_full (push_full),
        .rd_fill   (rd_fill),
        .rd_id     (fire_id)
    );

    tw_sweep_fsm #(.SLOTS(SLOTS), .DEPTH(DEPTH)) u_sweep (
        .clk        (clk),
        .rst_n      (rst_n),
        .now_slot   (now_slot),
        .rd_fill    (rd_fill),
        .fire_ready (fire_ready),
        .cursor     (cursor),
        .fire_valid (fire_valid),
        .pop        (pop)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pend_q       <= '0;
            ref_slot     <= '0;
            sched_reject <= 1'b0;
        end else begin
            pend_q       <= pend_q + PEND_W'(accept) - PEND_W'(pop);
            sched_reject <= sched_valid && !accept;
            if (accept && pend_q == '0) ref_slot <= now_slot;
        end
    end

    assign pending_count = pend_q;
endmodule

// File: rtl/timing_wheel_chk.sv
module timing_wheel_chk #(
    parameter int SLOTS  = 16,
    parameter int DEPTH  = 4,
    parameter int ID_W   = 8,
    parameter int DLY_W  = 8,
    parameter int PEND_W = 7
) (
    input logic              clk,
    input logic              rst_n,
    input logic              sched_valid,
    input logic [DLY_W-1:0]  sched_delay,
    input logic              sched_reject,
    input logic              fire_valid,
    input logic              fire_ready,
    input logic [ID_W-1:0]   fire_id,
    input logic [PEND_W-1:0] pending_count
);
    // R3: zero delay is refused
    a_r3_zero_delay_rejected: assert property (@(posedge clk) disable iff (!rst_n)
        sched_valid && sched_delay == '0 |=> sched_reject);

    // R9: held output stays put under backpressure
    a_r9_hold_valid: assert property (@(posedge clk) disable iff (!rst_n)
        fire_valid && !fire_ready |=> fire_valid);

    a_r9_hold_id: assert property (@(posedge clk) disable iff (!rst_n)
        fire_valid && !fire_ready && !sched_valid |=> $stable(fire_id));

    // R10: count bookkeeping
    a_r10_drop_on_fire: assert property (@(posedge clk) disable iff (!rst_n)
        !sched_valid && fire_valid && fire_ready |=> pending_count == $past(pending_count) - PEND_W'(1));

    a_r10_idle_stable: assert property (@(posedge clk) disable iff (!rst_n)
        !sched_valid && !(fire_valid && fire_ready) |=> $stable(pending_count));

    a_r10_empty_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        pending_count == '0 |-> !fire_valid);

    a_r10_bound: assert property (@(posedge clk) disable iff (!rst_n)
        pending_count <= PEND_W'(SLOTS * DEPTH));
endmodule

bind timing_wheel timing_wheel_chk #(
    .SLOTS(SLOTS), .DEPTH(DEPTH), .ID_W(ID_W), .DLY_W(DLY_W), .PEND_W(PEND_W)
) u_chk (
    .clk           (clk),
    .rst_n         (rst_n),
    .sched_valid   (sched_valid),
    .sched_delay   (sched_delay),
    .sched_reject  (sched_reject),
    .fire_valid    (fire_valid),
    .fire_ready    (fire_ready),
    .fire_id       (fire_id),
    .pending_count (pending_count)
);

// File: tb/timing_wheel_tb.sv
`timescale 1ns/1ps
module timing_wheel_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        sched_valid = 1'b0;
    logic [7:0]  sched_delay = '0;
    logic [7:0]  sched_id = '0;
    logic        sched_reject;
    logic [31:0] cyc_seq = '0, cyc_nseq = '0, cyc_idle = '0, cyc_copr = '0, cyc_fast = '0;
    logic        fire_valid;
    logic        fire_ready = 1'b1;
    logic [7:0]  fire_id;
    logic [6:0]  pending_count;

    int n_tests = 0;
    int n_fail  = 0;
    bit done    = 0;
    int nlog    = 0;
    int logv [64];

    always #10 clk = ~clk;

    timing_wheel u_dut (
        .clk(clk), .rst_n(rst_n),
        .sched_valid(sched_valid), .sched_delay(sched_delay), .sched_id(sched_id),
        .sched_reject(sched_reject),
        .cyc_seq(cyc_seq), .cyc_nseq(cyc_nseq), .cyc_idle(cyc_idle),
        .cyc_copr(cyc_copr), .cyc_fast(cyc_fast),
        .fire_valid(fire_valid), .fire_ready(fire_ready), .fire_id(fire_id),
        .pending_count(pending_count)
    );

    // Record every handshake just before the edge that completes it.
    always @(negedge clk) begin
        if (rst_n && fire_valid && fire_ready && nlog < 64) begin
            logv[nlog] = int'(fire_id);
            nlog = nlog + 1;
        end
    end

    task automatic check(input string req, input int act, input int exp);
        n_tests++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: actual %0d (0x%0h) expected %0d (0x%0h)", req, act, act, exp, exp);
        end
    endtask

    // Spread a total time over the five counters (R6).
    task automatic set_time(input int t);
        int a, b, c, d;
        a = t / 3; b = t / 5; c = t / 7; d = t / 11;
        @(negedge clk);
        cyc_seq  = 32'(a);
        cyc_nseq = 32'(b);
        cyc_idle = 32'(c);
        cyc_copr = 32'(d);
        cyc_fast = 32'(t - a - b - c - d);
    endtask

    task automatic settle();
        repeat (40) @(negedge clk);
    endtask

    task automatic sched(input int dly, input int id, output bit rej);
        @(negedge clk);
        sched_valid = 1'b1;
        sched_delay = 8'(dly);
        sched_id    = 8'(id);
        @(negedge clk);
        sched_valid = 1'b0;
        rej = sched_reject;
    endtask

    task automatic t_reset();
        check("R11 fire_valid", int'(fire_valid), 0);
        check("R11 sched_reject", int'(sched_reject), 0);
        check("R11 pending", int'(pending_count), 0);
    endtask

    task automatic t_basic();
        bit r;
        nlog = 0;
        sched(3, 'hA1, r);
        check("R1 accepted", int'(r), 0);
        check("R10 pending after accept", int'(pending_count), 1);
        set_time(2); settle();
        check("R1 not fired early", nlog, 0);
        set_time(3); settle();
        check("R1 fired count", nlog, 1);
        check("R1 fired id", logv[0], 'hA1);
        check("R10 pending drained", int'(pending_count), 0);
    endtask

    task automatic t_reference();
        bit r;
        nlog = 0;
        sched(2, 'hB1, r);
        set_time(4); settle();
        sched(2, 'hB2, r);
        set_time(5); settle();
        check("R2 both fired at reference slot", nlog, 2);
        check("R8 newest first", logv[0], 'hB2);
        check("R8 older second", logv[1], 'hB1);
    endtask

    task automatic t_zero_delay();
        bit r;
        nlog = 0;
        sched(0, 'h55, r);
        check("R3 reject flag", int'(r), 1);
        check("R3 pending unchanged", int'(pending_count), 0);
    endtask

    task automatic t_overflow();
        bit r;
        nlog = 0;
        for (int i = 0; i < 4; i++) begin
            sched(3, 'hC0 + i, r);
            check("R8 accepted within depth", int'(r), 0);
        end
        sched(3, 'hC4, r);
        check("R8 full slot rejects", int'(r), 1);
        check("R8 pending capped", int'(pending_count), 4);
        set_time(8); settle();
        check("R8 fired count", nlog, 4);
        for (int i = 0; i < 4; i++) check("R8 LIFO order", logv[i], 'hC3 - i);
    endtask

    task automatic t_backpressure();
        bit r;
        nlog = 0;
        sched(2, 'hD0, r);
        sched(2, 'hD1, r);
        fire_ready = 1'b0;
        set_time(10); settle();
        check("R9 valid held", int'(fire_valid), 1);
        check("R9 id held", int'(fire_id), 'hD1);
        repeat (5) @(negedge clk);
        check("R9 id still held", int'(fire_id), 'hD1);
        check("R10 pending while stalled", int'(pending_count), 2);
        check("R9 no handshake", nlog, 0);
        fire_ready = 1'b1;
        settle();
        check("R9 drained count", nlog, 2);
        check("R9 first out", logv[0], 'hD1);
        check("R9 second out", logv[1], 'hD0);
    endtask

    task automatic t_same_slot();
        bit r;
        nlog = 0;
        sched(3, 'hE0, r);
        set_time(26); settle();
        check("R7 equal slot fires nothing", nlog, 0);
        check("R7 pending kept", int'(pending_count), 1);
        set_time(29); settle();
        check("R7 later sweep fires", nlog, 1);
        check("R7 id", logv[0], 'hE0);
    endtask

    task automatic t_wrap();
        bit r;
        nlog = 0;
        sched(1, 'hF0, r);
        sched(4, 'hF1, r);
        sched(6, 'hF2, r);
        set_time(34); settle();
        check("R5 wrap count", nlog, 2);
        check("R5 high slot first", logv[0], 'hF0);
        check("R5 low slot after wrap", logv[1], 'hF1);
        set_time(35); settle();
        check("R6 summed time reaches slot 3", nlog, 3);
        check("R6 id", logv[2], 'hF2);
    endtask

    task automatic t_start_inclusive();
        bit r;
        nlog = 0;
        sched(16, 'h77, r);
        set_time(36); settle();
        check("R4 starting slot swept", nlog, 1);
        check("R4 id", logv[0], 'h77);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_basic();
        t_reference();
        t_zero_delay();
        t_overflow();
        t_backpressure();
        t_same_slot();
        t_wrap();
        t_start_inclusive();
        done = 1;
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_tests++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end
endmodule